// File: doc/BRIEF.md
# PAM4 Modulo-4 Precoder and Decoder

This block is the pair of symbol-rate circuits that sit at the two ends of a PAM4 serial link. The transmit stage computes a modulo-4 running difference of 2-bit symbols against its own previous output. This is the 1/(1+D) precoder. The receive stage adds each 2-bit slicer decision to the decision before it, modulo 4. This is the (1+D) decoder. Together they undo each other. They also keep the error propagation of a one-tap decision-feedback equalizer short: a long run of alternating decision errors reaches the decoded stream as only two wrong symbols, one where the run starts and one where it ends.

Each stage takes LANES symbols per clock on a valid-qualified bus. Lane 0 (bits [1:0]) is the earliest symbol of a beat. The recurrence is chained across the lanes within a cycle. A history register carries the last lane into the next beat. Both history registers load a programmable value in reset, and that value must match the far end. A shared enable gates both stages. A bypass control forwards symbols unchanged with the same latency as the active path.

Top module: `pam4_pc_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, both output valids clear and both output buses go to zero on that edge. The precoder history loads `pre_init` and the decoder history loads `dec_init`.
- R2: On an accepted precoder beat that is not in bypass, each output lane is p = (x − p_prev) mod 4. Here x is the lane's input symbol and p_prev is the previous lane's output, or the stored history for lane 0. Lane k occupies bits [2k+1:2k].
- R3: On an accepted decoder beat that is not in bypass, each output lane is r = (d + d_prev) mod 4. Here d_prev is the previous lane's input, or the stored history for lane 0.
- R4: After an accepted beat that is not in bypass, the precoder history becomes the last lane's output and the decoder history becomes the last lane's input. The recurrence therefore runs unbroken across beats.
- R5: A beat is accepted when its input valid and `en` are both high. Each output valid is high exactly one cycle after an accepted beat on its input.
- R6: A beat with input valid low leaves the history unchanged. The output valid drops and the output bus holds its previous value.
- R7: With `en` low, the input symbols and valids are ignored. The output valids are low and the histories are unchanged.
- R8: With `bypass` high, an accepted beat appears unchanged on the output one cycle later, and the history is not updated.
- R9: With `pre_init` = 2, the precoder maps 2 2 2 2 0 3 2 0 1 3 3 0 0 0 0 2 3 0 3 to 0 2 0 2 2 1 1 3 2 1 2 2 2 2 2 0 3 1 2.
- R10: With `dec_init` = 0, the decisions 0 1 1 1 3 0 2 2 3 0 3 1 3 1 3 0 3 1 2 decode, from the second symbol on, to 1 2 2 0 3 2 0 1 3 3 0 0 0 0 3 3 0 3.
- R11: When the precoder output is fed to the decoder with a decision error that alternates +1, −1, … over a run of symbols, the decoded stream differs from the transmitted data in exactly two symbols: the first symbol of the run and the symbol just after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable for both stages |
| bypass | input | 1 | Pass symbols through unchanged |
| pre_init | input | 2 | Reset value of the precoder history |
| dec_init | input | 2 | Reset value of the decoder history |
| tx_valid | input | 1 | Precoder input beat valid |
| tx_sym | input | 2*LANES | Precoder input symbols, lane 0 in bits [1:0] |
| pre_valid | output | 1 | Precoder output valid |
| pre_sym | output | 2*LANES | Precoded symbols |
| rx_valid | input | 1 | Decoder input beat valid |
| rx_sym | input | 2*LANES | Slicer decisions, lane 0 in bits [1:0] |
| dec_valid | output | 1 | Decoder output valid |
| dec_sym | output | 2*LANES | Decoded symbols |

## Verification
A wrong precoder history first shows in lane 0 of the next accepted beat, one cycle after that beat goes in. The fault does not heal: the feedback carries the offset into every later symbol, so every following precoded symbol is wrong. A wrong decoder history corrupts lane 0 of one output beat only, because the decoder has no feedback. A bench that compares every beat against a free-running model therefore catches a decoder fault on the single cycle it appears, and catches a precoder fault on every cycle after it.

// File: rtl/pam4_pc_pkg.sv
package pam4_pc_pkg;
    localparam int SYM_W = 2;
    typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/pam4_pc_chain.sv
// Combinational modulo-4 recurrence across the lanes of one beat.
// DIFF=1: running difference against previous output (precoder).
// DIFF=0: sum with previous input (decoder).
module pam4_pc_chain
    import pam4_pc_pkg::*;
#(
    parameter int LANES = 4,
    parameter bit DIFF  = 1'b1
) (
    input  sym_t                   hist,
    input  logic [LANES*SYM_W-1:0] in_sym,
    output logic [LANES*SYM_W-1:0] out_sym,
    output sym_t                   last
);
    localparam int W = LANES * SYM_W;

    sym_t prev_w [LANES+1];

    assign prev_w[0] = hist;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sym_t lane_in;
        sym_t lane_out;
        assign lane_in = in_sym[k*SYM_W +: SYM_W];
        if (DIFF) begin : g_diff
            assign lane_out      = lane_in - prev_w[k];
            assign prev_w[k+1]   = lane_out;
        end else begin : g_sum
            assign lane_out      = lane_in + prev_w[k];
            assign prev_w[k+1]   = lane_in;
        end
        assign out_sym[k*SYM_W +: SYM_W] = lane_out;
    end

    assign last = prev_w[LANES];

    logic unused_w;
    assign unused_w = ^W;
endmodule

// File: rtl/pam4_pc_stage.sv
// One registered stage: chain plus history and output registers.
module pam4_pc_stage
    import pam4_pc_pkg::*;
#(
    parameter int LANES = 4,
    parameter bit DIFF  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   bypass,
    input  sym_t                   init,
    input  logic                   in_valid,
    input  logic [LANES*SYM_W-1:0] in_sym,
    output logic                   out_valid,
    output logic [LANES*SYM_W-1:0] out_sym
);
    localparam int W = LANES * SYM_W;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] sym;
        sym_t         hist;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] chain_sym;
    sym_t         chain_last;

    pam4_pc_chain #(.LANES(LANES), .DIFF(DIFF)) u_chain (
        .hist    (st_q.hist),
        .in_sym  (in_sym),
        .out_sym (chain_sym),
        .last    (chain_last)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (en && in_valid) begin
            st_d.vld = 1'b1;
            if (bypass) begin
                st_d.sym = in_sym;
            end else begin
                st_d.sym  = chain_sym;
                st_d.hist = chain_last;
            end
        end
        if (rst) begin
            st_d.vld  = 1'b0;
            st_d.sym  = '0;
            st_d.hist = init;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sym   = st_q.sym;
endmodule

// File: rtl/pam4_pc_top.sv
module pam4_pc_top
    import pam4_pc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   bypass,
    input  logic [1:0]             pre_init,
    input  logic [1:0]             dec_init,
    input  logic                   tx_valid,
    input  logic [2*LANES-1:0]     tx_sym,
    output logic                   pre_valid,
    output logic [2*LANES-1:0]     pre_sym,
    input  logic                   rx_valid,
    input  logic [2*LANES-1:0]     rx_sym,
    output logic                   dec_valid,
    output logic [2*LANES-1:0]     dec_sym
);
    pam4_pc_stage #(.LANES(LANES), .DIFF(1'b1)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .bypass    (bypass),
        .init      (pre_init),
        .in_valid  (tx_valid),
        .in_sym    (tx_sym),
        .out_valid (pre_valid),
        .out_sym   (pre_sym)
    );

    pam4_pc_stage #(.LANES(LANES), .DIFF(1'b0)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .bypass    (bypass),
        .init      (dec_init),
        .in_valid  (rx_valid),
        .in_sym    (rx_sym),
        .out_valid (dec_valid),
        .out_sym   (dec_sym)
    );
endmodule

// File: rtl/pam4_pc_chk.sv
module pam4_pc_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 bypass,
    input logic                 tx_valid,
    input logic [2*LANES-1:0]   tx_sym,
    input logic                 pre_valid,
    input logic [2*LANES-1:0]   pre_sym,
    input logic                 rx_valid,
    input logic [2*LANES-1:0]   rx_sym,
    input logic                 dec_valid,
    input logic [2*LANES-1:0]   dec_sym
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pre_valid && !dec_valid && pre_sym == '0 && dec_sym == '0));

    // R5
    pre_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tx_valid) |=> pre_valid);

    // R5
    dec_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (en && rx_valid) |=> dec_valid);

    // R6
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(en && tx_valid) |=> (!pre_valid && $stable(pre_sym)));

    // R7
    dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!dec_valid && $stable(dec_sym)));

    // R8
    pre_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (en && bypass && tx_valid) |=> (pre_sym == $past(tx_sym)));

    // R8
    dec_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (en && bypass && rx_valid) |=> (dec_sym == $past(rx_sym)));
endmodule

bind pam4_pc_top pam4_pc_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .bypass    (bypass),
    .tx_valid  (tx_valid),
    .tx_sym    (tx_sym),
    .pre_valid (pre_valid),
    .pre_sym   (pre_sym),
    .rx_valid  (rx_valid),
    .rx_sym    (rx_sym),
    .dec_valid (dec_valid),
    .dec_sym   (dec_sym)
);

// File: tb/tb_pam4_pc_top.sv
`timescale 1ns/1ps
module tb_pam4_pc_top;
    localparam int LANES = 4;
    localparam int W     = 2 * LANES;

    logic         clk = 1'b0;
    logic         rst, en, bypass;
    logic [1:0]   pre_init, dec_init;
    logic         tx_valid, rx_valid;
    logic [W-1:0] tx_sym, rx_sym;
    logic         pre_valid, dec_valid;
    logic [W-1:0] pre_sym, dec_sym;

    always #5 clk = ~clk;

    pam4_pc_top #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .en(en), .bypass(bypass),
        .pre_init(pre_init), .dec_init(dec_init),
        .tx_valid(tx_valid), .tx_sym(tx_sym),
        .pre_valid(pre_valid), .pre_sym(pre_sym),
        .rx_valid(rx_valid), .rx_sym(rx_sym),
        .dec_valid(dec_valid), .dec_sym(dec_sym)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural model state
    int ph, dh;
    logic         e_pv, e_dv;
    logic [W-1:0] e_ps, e_ds;
    int pq[$];
    int dq[$];

    function automatic int m4(int v);
        return ((v % 4) + 4) % 4;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One beat: compare current outputs, capture, apply inputs, advance model.
    task automatic beat(input logic tv, input logic [W-1:0] ts,
                        input logic rv, input logic [W-1:0] rs);
        chk(cur_req, "pre_valid", int'(pre_valid), int'(e_pv));
        chk(cur_req, "pre_sym",   int'(pre_sym),   int'(e_ps));
        chk(cur_req, "dec_valid", int'(dec_valid), int'(e_dv));
        chk(cur_req, "dec_sym",   int'(dec_sym),   int'(e_ds));
        if (pre_valid) for (int k = 0; k < LANES; k++) pq.push_back(int'(pre_sym[2*k +: 2]));
        if (dec_valid) for (int k = 0; k < LANES; k++) dq.push_back(int'(dec_sym[2*k +: 2]));
        tx_valid = tv; tx_sym = ts; rx_valid = rv; rx_sym = rs;
        if (rst) begin
            e_pv = 0; e_dv = 0; e_ps = '0; e_ds = '0;
            ph = int'(pre_init); dh = int'(dec_init);
        end else begin
            e_pv = en && tv;
            if (en && tv) begin
                if (bypass) e_ps = ts;
                else for (int k = 0; k < LANES; k++) begin
                    ph = m4(int'(ts[2*k +: 2]) - ph);
                    e_ps[2*k +: 2] = ph[1:0];
                end
            end
            e_dv = en && rv;
            if (en && rv) begin
                if (bypass) e_ds = rs;
                else for (int k = 0; k < LANES; k++) begin
                    e_ds[2*k +: 2] = 2'(m4(int'(rs[2*k +: 2]) + dh));
                    dh = int'(rs[2*k +: 2]);
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] pi, input logic [1:0] di);
        rst = 1; pre_init = pi; dec_init = di;
        beat(0, '0, 0, '0);
        beat(0, '0, 0, '0);
        rst = 0;
    endtask

    function automatic logic [W-1:0] pack4(int a[$], int base);
        logic [W-1:0] v = '0;
        for (int k = 0; k < LANES; k++)
            if (base + k < a.size()) v[2*k +: 2] = 2'(a[base + k]);
        return v;
    endfunction

    int lcg = 32'h1234567;
    function automatic logic [W-1:0] rnd();
        lcg = lcg * 1103515245 + 12345;
        return W'(lcg >>> 7);
    endfunction

    initial begin
        int vin[$]  = '{2,2,2,2,0,3,2,0,1,3,3,0,0,0,0,2,3,0,3};
        int vout[$] = '{0,2,0,2,2,1,1,3,2,1,2,2,2,2,2,0,3,1,2};
        int din[$]  = '{0,1,1,1,3,0,2,2,3,0,3,1,3,1,3,0,3,1,2};
        int dout[$] = '{2,1,2,2,0,3,2,0,1,3,3,0,0,0,0,3,3,0,3};
        int txs[$];
        int ps[$];
        int ds[$];
        int p, miss, first_bad, second_bad;

        rst = 1; en = 1; bypass = 0; pre_init = 0; dec_init = 0;
        tx_valid = 0; rx_valid = 0; tx_sym = '0; rx_sym = '0;
        e_pv = 0; e_dv = 0; e_ps = '0; e_ds = '0; ph = 0; dh = 0;
        @(negedge clk);

        cur_req = "R1";
        do_reset(2'd3, 2'd1);

        // R2 R3 R4 R5: continuous random beats
        cur_req = "R2 R3 R4 R5";
        for (int i = 0; i < 40; i++) beat(1, rnd(), 1, rnd());

        // R6: valid gaps
        cur_req = "R6";
        for (int i = 0; i < 40; i++) beat(i % 3 == 0, rnd(), i % 2 == 0, rnd());

        // R7: enable low, inputs driven valid
        cur_req = "R7";
        en = 0;
        for (int i = 0; i < 6; i++) beat(1, rnd(), 1, rnd());
        en = 1;
        for (int i = 0; i < 4; i++) beat(1, rnd(), 1, rnd());

        // R8: bypass, then resume with history intact
        cur_req = "R8";
        bypass = 1;
        for (int i = 0; i < 8; i++) beat(1, rnd(), i % 2 == 1, rnd());
        bypass = 0;
        for (int i = 0; i < 6; i++) beat(1, rnd(), 1, rnd());

        // R9: precoder reference vector
        cur_req = "R9";
        do_reset(2'd2, 2'd0);
        pq.delete();
        for (int b = 0; b < 5; b++) beat(1, pack4(vin, 4*b), 0, '0);
        beat(0, '0, 0, '0);
        for (int i = 0; i < 19; i++) chk("R9", "ref precode", pq[i], vout[i]);

        // R10: decoder reference vector
        cur_req = "R10";
        do_reset(2'd2, 2'd0);
        dq.delete();
        for (int b = 0; b < 5; b++) beat(0, '0, 1, pack4(din, 4*b));
        beat(0, '0, 0, '0);
        for (int i = 1; i < 19; i++) chk("R10", "ref decode", dq[i], dout[i]);

        // R11: alternating decision error burst over symbols 5..17
        cur_req = "R11";
        do_reset(2'd1, 2'd1);
        p = 1;
        for (int i = 0; i < 32; i++) begin
            int t = int'(rnd()) & 3;
            txs.push_back(t);
            p = m4(t - p);
            ps.push_back(p);
            if (i >= 5 && i <= 17) ds.push_back(m4(p + (((i - 5) % 2 == 0) ? 1 : -1)));
            else ds.push_back(p);
        end
        dq.delete();
        for (int b = 0; b < 8; b++) beat(0, '0, 1, pack4(ds, 4*b));
        beat(0, '0, 0, '0);
        miss = 0; first_bad = -1; second_bad = -1;
        for (int i = 0; i < 32; i++) if (dq[i] != txs[i]) begin
            miss++;
            if (first_bad < 0) first_bad = i; else second_bad = i;
        end
        chk("R11", "burst error count", miss, 2);
        chk("R11", "entry error index", first_bad, 5);
        chk("R11", "exit error index", second_bad, 18);

        // R11: clean loopback through the precoder stage of the design
        do_reset(2'd1, 2'd1);
        pq.delete();
        for (int b = 0; b < 8; b++) beat(1, pack4(txs, 4*b), 0, '0);
        beat(0, '0, 0, '0);
        for (int i = 0; i < 32; i++) chk("R11", "precode matches model", pq[i], ps[i]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule